// File: doc/BRIEF.md
# Strided Video Memory Write Port

This block sits between a processor bus and a word-addressed video memory. Software does not address the video memory directly. It loads a 16-bit pointer and a 16-bit stride, then pushes words through one data register. Each pushed word is written at the pointer, and the pointer then moves on by the stride. Because the stride is programmable, one register can fill a row, a column or any regular pattern of cells without reloading the pointer.

The same register window also holds a 16-bit video control word and a 32-bit raster interrupt position, which is written as two 16-bit halves. A write to the acknowledge offset produces a one-cycle pulse and stores nothing.

A 32-bit bus write is treated as two word writes in a single cycle. The upper half goes to the given offset and is applied first. The lower half goes to the offset plus two and is applied second. All outputs are registered, so every effect of a bus write appears one clock after the write is presented.

Top module: `vp_port_top`

## Requirements
- R1: After reset, the control output, the position output, the memory write enable, the position load strobe and the acknowledge strobe are all zero. The pointer and stride registers are also zero.
- R2: A word write at offset 0x0 loads the pointer. The next data write uses the loaded value as its memory word address.
- R3: A word write at offset 0x2 raises the memory write enable for exactly one cycle, in the cycle after the bus write. In that cycle the word address equals the pointer and the data equals the written word.
- R4: After each data write, the pointer becomes (pointer + stride) mod 65536, so the pointer wraps past 0xFFFF.
- R5: A word write at offset 0x4 loads the stride used by later data writes.
- R6: A word write at offset 0x6 loads the video control output.
- R7: A word write at offset 0x8 replaces bits 31:16 of the position and keeps bits 15:0. A write at offset 0xA replaces bits 15:0 and keeps bits 31:16. Each such update pulses the position load strobe for one cycle.
- R8: A word write at offset 0xC pulses the acknowledge strobe for one cycle and changes no pointer, stride, control or position value.
- R9: A 32-bit write applies data bits 31:16 at the given offset and then bits 15:0 at the offset plus two. A 32-bit write at offset 0x0 therefore sets the pointer and then performs a data write at that pointer.
- R10: A write at any offset other than 0x0, 0x2, 0x4, 0x6, 0x8, 0xA or 0xC has no effect on any output or stored register. The offset is the low 16 bits of the bus address.
- R11: With a stride of zero, successive data writes all go to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request, one transfer per cycle |
| bus_long | input | 1 | 1: 32-bit transfer, 0: 16-bit transfer |
| bus_off | input | 16 | Register byte offset (low address bits) |
| bus_wdata | input | 32 | Write data; word writes use bits 15:0 |
| vram_we | output | 1 | Video memory write enable, one cycle per data write |
| vram_addr | output | 16 | Video memory word address |
| vram_wdata | output | 16 | Video memory write data |
| vid_ctl | output | 16 | Video control word |
| raster_pos | output | 32 | Raster interrupt position |
| raster_pos_ld | output | 1 | One-cycle pulse on each position update |
| irq_ack | output | 1 | One-cycle acknowledge pulse |

## Verification
The pointer and stride cannot be read back, so their values have to be inferred from the address of the next data write. Every scenario therefore ends with a data write that exposes the pointer, including the scenarios meant to leave state untouched, such as acknowledge writes and writes to unused offsets. The 32-bit write at offset 0x0 is the hardest case to bring about, because the pointer load and the data write that uses the new pointer happen in the same cycle. It is reached with a single long write whose upper half is a fresh pointer, and the bench then checks both the write address and the pointer after the stride step. Wrap-around is reached by loading a pointer near 0xFFFF with a stride that carries past it.

// File: rtl/vp_pkg.sv
package vp_pkg;

    localparam int VP_WORD = 16;

    typedef enum logic [2:0] {
        FN_NONE,
        FN_PTR,
        FN_DATA,
        FN_STRIDE,
        FN_CTRL,
        FN_POS_HI,
        FN_POS_LO,
        FN_ACK
    } vp_fn_e;

    typedef struct packed {
        logic [VP_WORD-1:0]   ptr;
        logic [VP_WORD-1:0]   stride;
        logic [VP_WORD-1:0]   ctl;
        logic [2*VP_WORD-1:0] pos;
        logic                 we;
        logic [VP_WORD-1:0]   waddr;
        logic [VP_WORD-1:0]   wdata;
        logic                 pos_ld;
        logic                 ack;
    } vp_state_t;

endpackage

// File: rtl/vp_word_split.sv
module vp_word_split #(
    parameter int OFF_W = 16,
    parameter int DW    = 16
) (
    input  logic                       bus_wr,
    input  logic                       bus_long,
    input  logic [OFF_W-1:0]           bus_off,
    input  logic [2*DW-1:0]            bus_wdata,
    output logic [1:0]                 slot_vld,
    output logic [1:0][OFF_W-1:0]      slot_off,
    output logic [1:0][DW-1:0]         slot_data
);
    localparam logic [OFF_W-1:0] STEP = OFF_W'(2);

    always_comb begin
        slot_vld[0]  = bus_wr;
        slot_off[0]  = bus_off;
        slot_data[0] = bus_long ? bus_wdata[2*DW-1:DW] : bus_wdata[DW-1:0];
        slot_vld[1]  = bus_wr & bus_long;
        slot_off[1]  = bus_off + STEP;
        slot_data[1] = bus_wdata[DW-1:0];
    end
endmodule

// File: rtl/vp_slot_decode.sv
module vp_slot_decode
    import vp_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             vld,
    input  logic [OFF_W-1:0] off,
    output vp_fn_e           fn
);
    always_comb begin
        fn = FN_NONE;
        if (vld) begin
            case (off)
                OFF_W'(16'h0): fn = FN_PTR;
                OFF_W'(16'h2): fn = FN_DATA;
                OFF_W'(16'h4): fn = FN_STRIDE;
                OFF_W'(16'h6): fn = FN_CTRL;
                OFF_W'(16'h8): fn = FN_POS_HI;
                OFF_W'(16'hA): fn = FN_POS_LO;
                OFF_W'(16'hC): fn = FN_ACK;
                default:       fn = FN_NONE;
            endcase
        end
    end
endmodule

// File: rtl/vp_port_top.sv
module vp_port_top
    import vp_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_long,
    input  logic [OFF_W-1:0]     bus_off,
    input  logic [2*VP_WORD-1:0] bus_wdata,
    output logic                 vram_we,
    output logic [VP_WORD-1:0]   vram_addr,
    output logic [VP_WORD-1:0]   vram_wdata,
    output logic [VP_WORD-1:0]   vid_ctl,
    output logic [2*VP_WORD-1:0] raster_pos,
    output logic                 raster_pos_ld,
    output logic                 irq_ack
);
    localparam int SLOTS = 2;

    logic [SLOTS-1:0]              slot_vld;
    logic [SLOTS-1:0][OFF_W-1:0]   slot_off;
    logic [SLOTS-1:0][VP_WORD-1:0] slot_data;
    vp_fn_e                        slot_fn [SLOTS];

    vp_state_t st_d, st_q;

    vp_word_split #(.OFF_W(OFF_W), .DW(VP_WORD)) u_split (
        .bus_wr    (bus_wr),
        .bus_long  (bus_long),
        .bus_off   (bus_off),
        .bus_wdata (bus_wdata),
        .slot_vld  (slot_vld),
        .slot_off  (slot_off),
        .slot_data (slot_data)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        vp_slot_decode #(.OFF_W(OFF_W)) u_dec (
            .vld (slot_vld[g]),
            .off (slot_off[g]),
            .fn  (slot_fn[g])
        );
    end

    // Slots are applied in order: the upper half of a long write lands first.
    always_comb begin
        st_d        = st_q;
        st_d.we     = 1'b0;
        st_d.pos_ld = 1'b0;
        st_d.ack    = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            case (slot_fn[i])
                FN_PTR:    st_d.ptr = slot_data[i];
                FN_DATA: begin
                    st_d.we    = 1'b1;
                    st_d.waddr = st_d.ptr;
                    st_d.wdata = slot_data[i];
                    st_d.ptr   = st_d.ptr + st_d.stride;
                end
                FN_STRIDE: st_d.stride = slot_data[i];
                FN_CTRL:   st_d.ctl = slot_data[i];
                FN_POS_HI: begin
                    st_d.pos[2*VP_WORD-1:VP_WORD] = slot_data[i];
                    st_d.pos_ld = 1'b1;
                end
                FN_POS_LO: begin
                    st_d.pos[VP_WORD-1:0] = slot_data[i];
                    st_d.pos_ld = 1'b1;
                end
                FN_ACK:    st_d.ack = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vram_we       = st_q.we;
    assign vram_addr     = st_q.waddr;
    assign vram_wdata    = st_q.wdata;
    assign vid_ctl       = st_q.ctl;
    assign raster_pos    = st_q.pos;
    assign raster_pos_ld = st_q.pos_ld;
    assign irq_ack       = st_q.ack;

    // R3: an enable pulse only ever follows a bus write
    a_r3_we_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> $past(bus_wr));

    // R4: a plain word data write advances the pointer by the stride
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && !bus_long && bus_off == OFF_W'(2))
            |-> st_q.ptr == $past(st_q.ptr + st_q.stride));

    // R7: the position only moves when the load strobe marks it
    a_r7_pos_marked: assert property (@(posedge clk) disable iff (!rst_n)
        !raster_pos_ld |-> $stable(raster_pos));

    // R8: acknowledge leaves control and stride untouched
    a_r8_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($stable(vid_ctl) && $stable(st_q.stride)));

    // R6: control changes only as a result of a bus write
    a_r6_ctl_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vid_ctl) |-> $past(bus_wr));
endmodule

// File: tb/sim_vp_port_top.sv
module sim_vp_port_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_long = 1'b0;
    logic [15:0] bus_off = '0;
    logic [31:0] bus_wdata = '0;
    logic        vram_we;
    logic [15:0] vram_addr, vram_wdata, vid_ctl;
    logic [31:0] raster_pos;
    logic        raster_pos_ld, irq_ack;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] m_ptr, m_stride, m_ctl;
    logic [31:0] m_pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    vp_port_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_long(bus_long),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .vram_we(vram_we),
        .vram_addr(vram_addr), .vram_wdata(vram_wdata), .vid_ctl(vid_ctl),
        .raster_pos(raster_pos), .raster_pos_ld(raster_pos_ld), .irq_ack(irq_ack)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Present one transfer, leave it for one edge, return at the next falling edge.
    task automatic wr(input logic lng, input logic [15:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_long = lng; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_long = 1'b0;
    endtask

    task automatic data_check(input string req, input logic [15:0] d);
        wr(1'b0, 16'h2, {16'h0, d});
        chk({req, " we"}, vram_we, 1'b1);
        chk({req, " addr"}, vram_addr, m_ptr);
        chk({req, " data"}, vram_wdata, d);
        m_ptr = m_ptr + m_stride;
        @(negedge clk);
        chk({req, " we one cycle"}, vram_we, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 ctl", vid_ctl, 0);
        chk("R1 pos", raster_pos, 0);
        chk("R1 we", vram_we, 0);
        chk("R1 ld", raster_pos_ld, 0);
        chk("R1 ack", irq_ack, 0);
        data_check("R1 ptr zero", 16'h1111);
        data_check("R11 zero stride", 16'h2222);
    endtask

    task automatic t_stream;
        wr(1'b0, 16'h0, 32'h0100); m_ptr = 16'h0100;
        wr(1'b0, 16'h4, 32'h0020); m_stride = 16'h0020;
        data_check("R2 R3 first", 16'hA001);
        data_check("R5 second", 16'hA002);
        data_check("R3 third", 16'hA003);
    endtask

    task automatic t_wrap;
        wr(1'b0, 16'h0, 32'hFFF0); m_ptr = 16'hFFF0;
        data_check("R4 before wrap", 16'h5A5A);
        data_check("R4 after wrap", 16'hA5A5);
    endtask

    task automatic t_ctrl_pos;
        wr(1'b0, 16'h6, 32'h00C3); m_ctl = 16'h00C3;
        chk("R6 ctl", vid_ctl, m_ctl);
        wr(1'b0, 16'h8, 32'h1234);
        chk("R7 hi", raster_pos, 32'h1234_0000);
        chk("R7 ld", raster_pos_ld, 1);
        @(negedge clk);
        chk("R7 ld one cycle", raster_pos_ld, 0);
        wr(1'b0, 16'hA, 32'hABCD);
        chk("R7 lo", raster_pos, 32'h1234_ABCD);
        wr(1'b0, 16'h8, 32'h0055);
        chk("R7 hi keeps lo", raster_pos, 32'h0055_ABCD);
        m_pos = 32'h0055_ABCD;
    endtask

    task automatic t_ack;
        wr(1'b0, 16'hC, 32'h0007);
        chk("R8 ack", irq_ack, 1);
        chk("R8 ctl", vid_ctl, m_ctl);
        chk("R8 pos", raster_pos, m_pos);
        chk("R8 we", vram_we, 0);
        @(negedge clk);
        chk("R8 ack one cycle", irq_ack, 0);
        data_check("R8 ptr kept", 16'h0E0E);
    endtask

    task automatic t_long;
        wr(1'b1, 16'h0, 32'h0200_BEEF); m_ptr = 16'h0200;
        chk("R9 long ptr we", vram_we, 1);
        chk("R9 long ptr addr", vram_addr, 16'h0200);
        chk("R9 long ptr data", vram_wdata, 16'hBEEF);
        m_ptr = m_ptr + m_stride;
        wr(1'b1, 16'h4, 32'h0003_00AA); m_stride = 16'h0003; m_ctl = 16'h00AA;
        chk("R9 long stride ctl", vid_ctl, m_ctl);
        wr(1'b1, 16'h8, 32'hCAFE_F00D); m_pos = 32'hCAFE_F00D;
        chk("R9 long pos", raster_pos, m_pos);
        data_check("R9 after long", 16'h7777);
        data_check("R9 stride three", 16'h8888);
    endtask

    task automatic t_ignored;
        wr(1'b0, 16'hE, 32'h1234);
        wr(1'b0, 16'h1, 32'h1234);
        wr(1'b0, 16'h0010, 32'h1234);
        wr(1'b0, 16'h8000, 32'h1234);
        chk("R10 we", vram_we, 0);
        chk("R10 ack", irq_ack, 0);
        chk("R10 ld", raster_pos_ld, 0);
        chk("R10 ctl", vid_ctl, m_ctl);
        chk("R10 pos", raster_pos, m_pos);
        data_check("R10 ptr kept", 16'h9999);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog got=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        m_ptr = '0; m_stride = '0; m_ctl = '0; m_pos = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_wrap();
        t_ctrl_pos();
        t_ack();
        t_long();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule